// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by reading a four-level radix translation table held in memory. A requester hands over the virtual address. The walk begins at the table named by a root base input, and each table level takes one 64-bit entry read over a valid/ready memory request channel. The entry read data returns on a separate valid strobe.

Every table fills one 4 KiB page with 512 entries. Each level is therefore indexed by a 9-bit slice of the virtual address. An entry at the second or third level can carry a size flag, and that flag ends the walk early with a 2 MiB or a 1 GiB mapping. An entry with its present flag clear ends the walk with a fault. Only one walk runs at a time. The result stays on the response port until the requester takes it.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1 while mem_req_valid and rsp_valid are 0.
- R2: Each entry read address is the current table frame (bits [51:12]) followed by the 9-bit index and three zero bits. The first table frame is root_base[51:12], and the index for the levels from top to bottom is vaddr [47:39], [38:30], [29:21], [20:12].
- R3: A walk in which all four levels are present and no size flag is honoured makes exactly four reads. It answers rsp_size=0 (4K) and rsp_paddr={L1 entry[51:12], vaddr[11:0]}.
- R4: If the second-level entry is present with bit 7 set, the walk stops after three reads. It answers rsp_size=1 (2M) and rsp_paddr={entry[51:21], vaddr[20:0]}.
- R5: If the third-level entry is present with bit 7 set, the walk stops after two reads. It answers rsp_size=2 (1G) and rsp_paddr={entry[51:30], vaddr[29:0]}.
- R6: Bit 7 has no effect in the top-level and the lowest-level entries. Bits [6:1] and [63:52] of an entry have no effect at any level.
- R7: An entry with bit 0 (present) clear at any level ends the walk with no further read. The response is rsp_fault=1, rsp_paddr=0 and rsp_size=0.
- R8: req_ready is 0 from the cycle after a request is accepted until the response has been accepted. A request offered during that time is ignored.
- R9: While rsp_valid is 1 and rsp_ready is 0, the response fields stay unchanged and rsp_valid stays 1.
- R10: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_valid stays 1 and mem_req_addr stays unchanged. The memory request and the response are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 48 | Virtual address to translate |
| root_base | input | 52 | Physical base of the top-level table (bits [11:0] unused) |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 52 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 52 | Physical address (0 on fault) |
| rsp_size | output | 2 | 0 = 4K, 1 = 2M, 2 = 1G |
| rsp_fault | output | 1 | Walk hit a non-present entry |

## Verification
The function that can collide with a pending result is request intake. A held result and a new request offer can share the same cycles. The bench provokes this by holding rsp_ready low for several cycles on a share of the walks while it offers a new request with a different virtual address. It expects req_ready to stay low and the held physical address, size and fault flag to stay put. The next walk must then start cleanly from the address that is offered afterwards.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W     = 48;
    localparam int PA_W     = 52;
    localparam int PTE_W    = 64;
    localparam int IDX_W    = 9;
    localparam int PG_OFF   = 12;
    localparam int LEVELS   = 4;
    localparam int ENT_SH   = 3;
    localparam int FRAME_W  = PA_W - PG_OFF;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int PRESENT_BIT = 0;
    localparam int SIZE_BIT    = 7;
    // one bit per level (0 = lowest): where the size flag ends a walk
    localparam logic [LEVELS-1:0] LEAF_OK_MASK = 4'b0110;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic               present;
        logic               leaf;
        pg_size_e           size;
        logic [FRAME_W-1:0] frame;
    } pte_dec_t;

    function automatic pg_size_e size_of_level(lvl_t l);
        case (l)
            lvl_t'(0): return PG_4K;
            lvl_t'(1): return PG_2M;
            default:   return PG_1G;
        endcase
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [FRAME_W-1:0] base,
    input  logic [VA_W-1:0]    vaddr,
    input  lvl_t               level,
    output logic [PA_W-1:0]    addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx  = vaddr[PG_OFF + IDX_W*int'(level) +: IDX_W];
        addr = {base, idx, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  lvl_t             level,
    output pte_dec_t         dec
);
    logic size_flag_honoured;

    always_comb begin
        size_flag_honoured = pte[SIZE_BIT] && LEAF_OK_MASK[level];
        dec.present = pte[PRESENT_BIT];
        dec.leaf    = (level == lvl_t'(0)) || size_flag_honoured;
        dec.size    = size_of_level(level);
        dec.frame   = pte[PA_W-1:PG_OFF];
    end
endmodule

// File: rtl/ptw_pa_build.sv
module ptw_pa_build
    import ptw_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    input  logic [VA_W-1:0]    vaddr,
    input  pg_size_e           size,
    output logic [PA_W-1:0]    paddr
);
    logic [PA_W-1:0] cand [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_cand
        // mapping of a level-g leaf: upper frame bits, lower offset bits from the VA
        assign cand[g] = {frame[FRAME_W-1:g*IDX_W], vaddr[PG_OFF+g*IDX_W-1:0]};
    end

    always_comb paddr = cand[size];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PA_W-1:0]  root_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_size,
    output logic             rsp_fault
);
    walk_state_e        state_q;
    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] base_q;
    lvl_t               lvl_q;
    logic [PA_W-1:0]    paddr_q;
    pg_size_e           size_q;
    logic               fault_q;

    pte_dec_t           dec;
    logic [PA_W-1:0]    leaf_pa;

    ptw_addr_gen u_addr (
        .base  (base_q),
        .vaddr (va_q),
        .level (lvl_q),
        .addr  (mem_req_addr)
    );

    ptw_entry_dec u_dec (
        .pte   (mem_rsp_data),
        .level (lvl_q),
        .dec   (dec)
    );

    ptw_pa_build u_pa (
        .frame (dec.frame),
        .vaddr (va_q),
        .size  (dec.size),
        .paddr (leaf_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            base_q  <= '0;
            lvl_q   <= '0;
            paddr_q <= '0;
            size_q  <= PG_4K;
            fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        base_q  <= root_base[PA_W-1:PG_OFF];
                        lvl_q   <= lvl_t'(LEVELS-1);
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!dec.present) begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            size_q  <= PG_4K;
                            state_q <= ST_DONE;
                        end else if (dec.leaf) begin
                            fault_q <= 1'b0;
                            paddr_q <= leaf_pa;
                            size_q  <= dec.size;
                            state_q <= ST_DONE;
                        end else begin
                            base_q  <= dec.frame;
                            lvl_q   <= lvl_q - lvl_t'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign rsp_valid     = (state_q == ST_DONE);
    assign rsp_paddr     = paddr_q;
    assign rsp_size      = size_q;
    assign rsp_fault     = fault_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_size,
    input logic             rsp_fault
);
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_result_blocks_intake_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_size) && $stable(rsp_fault)));

    assert_memreq_held_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_valid && rsp_valid));

    assert_entry_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0));

    assert_fault_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_size == 2'd0));

    assert_size_code_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_size != 2'd3));
endmodule

bind pt_walker ptw_checker u_chk (.*);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [51:0] root_base = 52'h0_00C0_FFEE_0ABC;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [51:0] rsp_paddr;
    logic [1:0]  rsp_size;
    logic        rsp_fault;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_size(rsp_size), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // frame stored in the entry read at level lvl (3 = top, 0 = lowest)
    function automatic logic [39:0] frame_for(int lvl, logic [47:0] va);
        return (40'h5A_0000_0000 + 40'(lvl) * 40'h01_0001_1000) ^ {4'h0, va[47:12]};
    endfunction

    function automatic logic [51:0] read_addr(int lvl, logic [47:0] va);
        logic [39:0] base;
        base = (lvl == 3) ? root_base[51:12] : frame_for(lvl + 1, va);
        return {base, va[12 + 9*lvl +: 9], 3'b000};
    endfunction

    // mode: 0 4K, 1 2M, 2 1G, 3 size flag at top+lowest (ignored), 4..7 fault at level mode-4
    function automatic logic [63:0] entry_for(int lvl, logic [47:0] va, int mode);
        logic ps, pr;
        pr = !(mode >= 4 && lvl == mode - 4);
        ps = (mode == 1 && lvl == 1) || (mode == 2 && lvl == 2) ||
             (mode == 3 && (lvl == 3 || lvl == 0));
        return {12'hFA5, frame_for(lvl, va), 4'h0, ps, 6'h3F, pr};
    endfunction

    task automatic walk(input logic [47:0] va, input int mode, input bit hold);
        int end_lvl;
        logic [39:0] f;
        logic [51:0] exp_pa;
        logic [1:0]  exp_sz;
        logic [51:0] held_pa;
        end_lvl = (mode == 1) ? 1 : (mode == 2) ? 2 : (mode >= 4) ? mode - 4 : 0;
        chk("R8 idle ready", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = ~va;
        for (int lvl = 3; lvl >= end_lvl; lvl--) begin
            while (!mem_req_valid) @(negedge clk);
            chk("R2 entry address", 64'(mem_req_addr), 64'(read_addr(lvl, va)));
            repeat (lvl % 2) begin
                @(negedge clk);
                chk("R10 request held", 64'({mem_req_valid, mem_req_addr}),
                    64'({1'b1, read_addr(lvl, va)}));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (lvl) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = entry_for(lvl, va, mode);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
        end
        while (!rsp_valid) @(negedge clk);
        f = frame_for(end_lvl, va);
        if (mode >= 4) begin
            exp_pa = '0; exp_sz = 2'd0;
        end else if (end_lvl == 1) begin
            exp_pa = {f[39:9], va[20:0]}; exp_sz = 2'd1;
        end else if (end_lvl == 2) begin
            exp_pa = {f[39:18], va[29:0]}; exp_sz = 2'd2;
        end else begin
            exp_pa = {f, va[11:0]}; exp_sz = 2'd0;
        end
        case (mode)
            0: chk("R3 4K result", 64'({rsp_fault, rsp_size, rsp_paddr}), 64'({1'b0, exp_sz, exp_pa}));
            1: chk("R4 2M result", 64'({rsp_fault, rsp_size, rsp_paddr}), 64'({1'b0, exp_sz, exp_pa}));
            2: chk("R5 1G result", 64'({rsp_fault, rsp_size, rsp_paddr}), 64'({1'b0, exp_sz, exp_pa}));
            3: chk("R6 flag ignored", 64'({rsp_fault, rsp_size, rsp_paddr}), 64'({1'b0, exp_sz, exp_pa}));
            default: chk("R7 fault result", 64'({rsp_fault, rsp_size, rsp_paddr}), 64'({1'b1, exp_sz, exp_pa}));
        endcase
        chk("R7 no read after end", 64'(mem_req_valid), 64'd0);
        if (hold) begin
            held_pa   = rsp_paddr;
            req_valid = 1'b1;
            req_vaddr = va ^ 48'h0F0F_F0F0_1234;
            repeat (3) begin
                @(negedge clk);
                chk("R8 busy not ready", 64'(req_ready), 64'd0);
                chk("R9 result held", 64'({rsp_valid, rsp_fault, rsp_size, rsp_paddr}),
                    64'({1'b1, mode >= 4, exp_sz, held_pa}));
            end
            req_valid = 1'b0;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R8 ready after accept", 64'({req_ready, rsp_valid}), 64'({1'b1, 1'b0}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", 64'({req_ready, mem_req_valid, rsp_valid}), 64'({1'b1, 1'b0, 1'b0}));
        for (int i = 0; i < 16; i++) begin
            for (int mode = 0; mode < 8; mode++) begin
                logic [47:0] va;
                va = 48'(64'h9E37_79B9_7F4A_7C15 * 64'(i * 8 + mode + 1));
                walk(va, mode, ((i + mode) % 3) == 0);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule